// File: doc/BRIEF.md
# Super I/O Configuration Register File

This block is the configuration space of a multi-function I/O controller. A host reaches every register through two adjacent I/O addresses: the even one holds a pointer (the index), and the odd one reads or writes whichever register the pointer selects. One register selects a logical device number, and a bank of per-device registers sits behind it. This lets one small address window configure up to fifteen devices, each with its own enable, two base addresses, interrupt, DMA and device-specific bytes.

A bank of global registers sits next to the device banks. One global register carries a sticky lock bit. Once the lock is set, most of the global registers cannot be written again until reset. A read-only identification byte heads the global bank. Bit 0 of that byte also acts as a master gate on every device enable.

Every stored value is exported on flat output buses, so decode logic downstream can place the devices in the I/O map. The host bus has no back-pressure: every strobe is accepted in the cycle it is presented. Reads are combinational. Writes take effect at the next clock edge. A strap input, sampled while reset is held, moves the index/data pair between two base addresses.

Top module: `sio_cfg_regfile`

## Requirements
- R1: The port pair decodes at addresses BASE_LO/BASE_LO+1 (0x2E/0x2F) when `strap_hi` was low during reset, and at BASE_HI/BASE_HI+1 (0x4E/0x4F) when it was high. A write at the even address loads the index, and a read at the even address returns it. An access at any other address changes nothing and reads 0x00.
- R2: Index 0x07 holds the logical device number (LDN). A write is accepted only when the value is at most 0x0E; larger values leave the LDN unchanged.
- R3: Index 0x20 always reads 0xE9, and writes to it are ignored. Index 0x27 reads 0x01. Indices 0x26 and 0x29 read 0x00 and ignore writes.
- R4: A write to index 0x21 with bit 7 set stores the byte and sets a lock. The lock is cleared only by reset, and bit 7 of 0x21 then reads 1.
- R5: While the lock is set, writes to indices 0x21, 0x22, 0x23, 0x24, 0x25, 0x2A and 0x2B are discarded.
- R6: Indices 0x28, 0x2C and 0x2D accept writes whether or not the lock is set, and store the value ANDed with 0xF3.
- R7: Locked-group masks: 0x23 stores value & 0xF7, 0x25 stores value & 0xF3, 0x2B stores value & 0x4F. 0x21, 0x22, 0x24 and 0x2A store the value unmasked.
- R8: Index 0x30 stores the selected device's enable as written bit 0 AND bit 0 of the identification byte. It reads back as 0x00 or 0x01 and drives `ld_active[ldn]`.
- R9: The per-device registers are banked by the LDN: 0x60/0x61 (primary base high/low), 0x62/0x63 (secondary base high/low), 0x70 (value & 0x1F), 0x71 (unmasked), 0x74 and 0x75 (value & 0x1F), and 0xF0–0xF2 (unmasked). Each is exported for every device: base = {high,low}, config = {F2,F1,F0}.
- R10: Reading any index that maps to no register returns 0x00.
- R11: Reset gives the following defaults. LDN 0: base 0x3F2, interrupt 6, DMA 2, F0 = 0x24. LDN 1: base 0x278, interrupt 7. LDN 2: base 0x2F8, interrupt 3. LDN 3: base 0x3F8, interrupt 4. All enables are 0, the index and LDN are 0, and every other per-device register is 0x00.
- R12: `host_rdata` is 0x00 whenever `host_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strap_hi | input | 1 | Base-address strap, sampled while reset is held |
| host_addr | input | IO_AW (16) | Host I/O address |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational |
| ld_active | output | NUM_LDN (15) | Device enables, bit n for LDN n |
| ld_base0 | output | NUM_LDN*16 | Primary base per device |
| ld_base1 | output | NUM_LDN*16 | Secondary base per device |
| ld_irq_sel | output | NUM_LDN*8 | Interrupt select byte (0x70) per device |
| ld_irq_type | output | NUM_LDN*8 | Interrupt type byte (0x71) per device |
| ld_dma0 | output | NUM_LDN*8 | First DMA select (0x74) per device |
| ld_dma1 | output | NUM_LDN*8 | Second DMA select (0x75) per device |
| ld_cfg | output | NUM_LDN*24 | Device-specific bytes {F2,F1,F0} per device |
| glob_cfg | output | 14*8 | Global bank, byte k = index 0x20+k |

## Verification
The bench builds the block with its default parameters: fifteen devices, a 16-bit address and the identification byte 0xE9. These values put every device bank, the LDN upper limit 0x0E and the first illegal value 0x0F within reach of both directed and random writes. The bench applies reset twice, once with each strap level, so both base addresses are decoded, and it checks that the lock is cleared between the two runs. Because the identification byte has bit 0 set, the enable gate follows the written bit.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int GLOB_N   = 14;
  localparam int NSLOT    = 11;
  localparam logic [7:0] IDX_LDN  = 8'h07;
  localparam logic [7:0] IDX_GLOB = 8'h20;
  localparam logic [7:0] IDX_ACT  = 8'h30;
  localparam logic [7:0] M_G3  = 8'hF7;
  localparam logic [7:0] M_G5  = 8'hF3;
  localparam logic [7:0] M_GB  = 8'h4F;
  localparam logic [7:0] M_FREE = 8'hF3;
  localparam logic [7:0] M_SEL = 8'h1F;

  // slot numbers of the per-device byte storage
  localparam int S_B0H = 0, S_B0L = 1, S_B1H = 2, S_B1L = 3;
  localparam int S_IRQN = 4, S_IRQT = 5, S_DMA0 = 6, S_DMA1 = 7;
  localparam int S_CF0 = 8, S_CF1 = 9, S_CF2 = 10;
  localparam logic [3:0] S_NONE = 4'd15;

  function automatic logic [3:0] slot_of(input logic [7:0] idx);
    case (idx)
      8'h60: return 4'(S_B0H);
      8'h61: return 4'(S_B0L);
      8'h62: return 4'(S_B1H);
      8'h63: return 4'(S_B1L);
      8'h70: return 4'(S_IRQN);
      8'h71: return 4'(S_IRQT);
      8'h74: return 4'(S_DMA0);
      8'h75: return 4'(S_DMA1);
      8'hF0: return 4'(S_CF0);
      8'hF1: return 4'(S_CF1);
      8'hF2: return 4'(S_CF2);
      default: return S_NONE;
    endcase
  endfunction

  function automatic logic [7:0] slot_mask(input logic [3:0] s);
    if (s == 4'(S_IRQN) || s == 4'(S_DMA0) || s == 4'(S_DMA1)) return M_SEL;
    return 8'hFF;
  endfunction

  function automatic logic [7:0] ldn_default(input int ld, input int s);
    logic [7:0] v;
    v = 8'h00;
    case (ld)
      0: case (s)
           S_B0H: v = 8'h03;  S_B0L: v = 8'hF2;
           S_IRQN: v = 8'h06; S_DMA0: v = 8'h02; S_CF0: v = 8'h24;
           default: v = 8'h00;
         endcase
      1: case (s)
           S_B0H: v = 8'h02;  S_B0L: v = 8'h78; S_IRQN: v = 8'h07;
           default: v = 8'h00;
         endcase
      2: case (s)
           S_B0H: v = 8'h02;  S_B0L: v = 8'hF8; S_IRQN: v = 8'h03;
           default: v = 8'h00;
         endcase
      3: case (s)
           S_B0H: v = 8'h03;  S_B0L: v = 8'hF8; S_IRQN: v = 8'h04;
           default: v = 8'h00;
         endcase
      default: v = 8'h00;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/sio_host_port.sv
module sio_host_port #(
  parameter int IO_AW = 16,
  parameter logic [15:0] BASE_LO = 16'h002E,
  parameter logic [15:0] BASE_HI = 16'h004E
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strap_hi,
  input  logic [IO_AW-1:0] host_addr,
  input  logic             host_wr,
  input  logic             host_rd,
  input  logic [7:0]       host_wdata,
  output logic [7:0]       index,
  output logic             data_wr,
  output logic             data_rd,
  output logic             idx_rd
);
  logic             use_hi;
  logic [IO_AW-1:0] base;
  logic             hit;

  always_ff @(posedge clk) begin
    if (rst) use_hi <= strap_hi;
  end

  assign base = use_hi ? IO_AW'(BASE_HI) : IO_AW'(BASE_LO);
  assign hit  = host_addr[IO_AW-1:1] == base[IO_AW-1:1];

  assign data_wr = hit & host_wr & host_addr[0];
  assign data_rd = hit & host_rd & host_addr[0];
  assign idx_rd  = hit & host_rd & ~host_addr[0];

  always_ff @(posedge clk) begin
    if (rst)                               index <= 8'h00;
    else if (hit && host_wr && !host_addr[0]) index <= host_wdata;
  end

  a_r1_index_load: assert property (@(posedge clk) disable iff (rst)
    (hit && host_wr && !host_addr[0]) |=> (index == $past(host_wdata)));
  a_r1_miss_keeps: assert property (@(posedge clk) disable iff (rst)
    (!hit) |=> $stable(index));
endmodule

// File: rtl/sio_glob_bank.sv
module sio_glob_bank
  import sio_cfg_pkg::*;
#(
  parameter logic [7:0] CHIP_ID = 8'hE9,
  parameter logic [7:0] G7_DEF  = 8'h01
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [3:0]          off,
  input  logic [7:0]          wdata,
  output logic [GLOB_N*8-1:0] glob_flat,
  output logic                lock
);
  logic [7:0] g [GLOB_N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < GLOB_N; k++) g[k] <= 8'h00;
      g[0] <= CHIP_ID;
      g[7] <= G7_DEF;
      lock <= 1'b0;
    end else if (wr_en) begin
      case (off)
        4'd1: if (!lock) begin
          g[1] <= wdata;
          if (wdata[7]) lock <= 1'b1;
        end
        4'd2:  if (!lock) g[2]  <= wdata;
        4'd3:  if (!lock) g[3]  <= wdata & M_G3;
        4'd4:  if (!lock) g[4]  <= wdata;
        4'd5:  if (!lock) g[5]  <= wdata & M_G5;
        4'd10: if (!lock) g[10] <= wdata;
        4'd11: if (!lock) g[11] <= wdata & M_GB;
        4'd8:  g[8]  <= wdata & M_FREE;
        4'd12: g[12] <= wdata & M_FREE;
        4'd13: g[13] <= wdata & M_FREE;
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < GLOB_N; k++) begin : g_out
    assign glob_flat[k*8 +: 8] = g[k];
  end

  a_r4_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    lock |=> lock);
  a_r5_locked_frozen: assert property (@(posedge clk) disable iff (rst)
    (lock && wr_en && off == 4'd2) |=> $stable(g[2]));
  a_r6_free_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && off == 4'd12) |=> (g[12] == ($past(wdata) & 8'hF3)));
  a_r3_id_const: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> $stable(g[0]));
endmodule

// File: rtl/sio_ldn_bank.sv
module sio_ldn_bank
  import sio_cfg_pkg::*;
#(
  parameter int NUM_LDN = 15,
  parameter int LDN_W   = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LDN_W-1:0]     ldn,
  input  logic [7:0]           index,
  input  logic                 data_wr,
  input  logic [7:0]           wdata,
  input  logic                 act_gate,
  output logic [7:0]           rd_byte,
  output logic                 rd_hit,
  output logic [NUM_LDN-1:0]    ld_active,
  output logic [NUM_LDN*16-1:0] ld_base0,
  output logic [NUM_LDN*16-1:0] ld_base1,
  output logic [NUM_LDN*8-1:0]  ld_irq_sel,
  output logic [NUM_LDN*8-1:0]  ld_irq_type,
  output logic [NUM_LDN*8-1:0]  ld_dma0,
  output logic [NUM_LDN*8-1:0]  ld_dma1,
  output logic [NUM_LDN*24-1:0] ld_cfg
);
  logic [3:0]          slot;
  logic                slot_ok;
  logic                is_act;
  logic [7:0]          wval;
  logic [NUM_LDN*8-1:0] rd_all;

  assign slot    = slot_of(index);
  assign slot_ok = slot != S_NONE;
  assign is_act  = index == IDX_ACT;
  assign wval    = wdata & slot_mask(slot);

  for (genvar d = 0; d < NUM_LDN; d++) begin : g_dev
    logic [7:0] r [NSLOT];
    logic       act_q;
    logic       sel;

    assign sel = data_wr && (ldn == LDN_W'(d));

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int s = 0; s < NSLOT; s++) r[s] <= ldn_default(d, s);
        act_q <= 1'b0;
      end else if (sel) begin
        if (slot_ok) r[slot] <= wval;
        if (is_act)  act_q   <= wdata[0] & act_gate;
      end
    end

    assign rd_all[d*8 +: 8] = slot_ok ? r[slot] : {7'b0, act_q};
    assign ld_active[d]          = act_q;
    assign ld_base0[d*16 +: 16]  = {r[S_B0H], r[S_B0L]};
    assign ld_base1[d*16 +: 16]  = {r[S_B1H], r[S_B1L]};
    assign ld_irq_sel[d*8 +: 8]  = r[S_IRQN];
    assign ld_irq_type[d*8 +: 8] = r[S_IRQT];
    assign ld_dma0[d*8 +: 8]     = r[S_DMA0];
    assign ld_dma1[d*8 +: 8]     = r[S_DMA1];
    assign ld_cfg[d*24 +: 24]    = {r[S_CF2], r[S_CF1], r[S_CF0]};
  end

  assign rd_hit  = (slot_ok || is_act) && (int'(ldn) < NUM_LDN);
  assign rd_byte = rd_hit ? rd_all[int'(ldn)*8 +: 8] : 8'h00;

  a_r8_act_clear: assert property (@(posedge clk) disable iff (rst)
    (data_wr && is_act && !wdata[0] && int'(ldn) < NUM_LDN)
      |=> !ld_active[int'(ldn)]);
  a_r9_other_bank_stable: assert property (@(posedge clk) disable iff (rst)
    (data_wr && ldn != '0) |=> $stable(ld_base0[15:0]));
endmodule

// File: rtl/sio_cfg_regfile.sv
module sio_cfg_regfile
  import sio_cfg_pkg::*;
#(
  parameter int          NUM_LDN = 15,
  parameter int          IO_AW   = 16,
  parameter logic [15:0] BASE_LO = 16'h002E,
  parameter logic [15:0] BASE_HI = 16'h004E,
  parameter logic [7:0]  CHIP_ID = 8'hE9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  strap_hi,
  input  logic [IO_AW-1:0]      host_addr,
  input  logic                  host_wr,
  input  logic                  host_rd,
  input  logic [7:0]            host_wdata,
  output logic [7:0]            host_rdata,
  output logic [NUM_LDN-1:0]    ld_active,
  output logic [NUM_LDN*16-1:0] ld_base0,
  output logic [NUM_LDN*16-1:0] ld_base1,
  output logic [NUM_LDN*8-1:0]  ld_irq_sel,
  output logic [NUM_LDN*8-1:0]  ld_irq_type,
  output logic [NUM_LDN*8-1:0]  ld_dma0,
  output logic [NUM_LDN*8-1:0]  ld_dma1,
  output logic [NUM_LDN*24-1:0] ld_cfg,
  output logic [GLOB_N*8-1:0]   glob_cfg
);
  localparam int LDN_W = $clog2(NUM_LDN);
  localparam logic [7:0] LDN_MAX = 8'(NUM_LDN - 1);

  logic [7:0]       index;
  logic             data_wr, data_rd, idx_rd;
  logic [LDN_W-1:0] ldn;
  logic             glob_hit;
  logic [3:0]       goff;
  logic             lock;
  logic [7:0]       dev_byte;
  logic             dev_hit;
  logic [7:0]       gbyte;

  sio_host_port #(.IO_AW(IO_AW), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI)) u_port (
    .clk, .rst, .strap_hi, .host_addr, .host_wr, .host_rd, .host_wdata,
    .index, .data_wr, .data_rd, .idx_rd
  );

  always_ff @(posedge clk) begin
    if (rst) ldn <= '0;
    else if (data_wr && index == IDX_LDN && host_wdata <= LDN_MAX)
      ldn <= host_wdata[LDN_W-1:0];
  end

  assign glob_hit = (index >= IDX_GLOB) && (index < IDX_GLOB + 8'(GLOB_N));
  assign goff     = 4'(index - IDX_GLOB);

  sio_glob_bank #(.CHIP_ID(CHIP_ID), .G7_DEF(8'h01)) u_glob (
    .clk, .rst, .wr_en(data_wr && glob_hit), .off(goff),
    .wdata(host_wdata), .glob_flat(glob_cfg), .lock
  );

  sio_ldn_bank #(.NUM_LDN(NUM_LDN), .LDN_W(LDN_W)) u_dev (
    .clk, .rst, .ldn, .index, .data_wr, .wdata(host_wdata),
    .act_gate(glob_cfg[0]), .rd_byte(dev_byte), .rd_hit(dev_hit),
    .ld_active, .ld_base0, .ld_base1, .ld_irq_sel, .ld_irq_type,
    .ld_dma0, .ld_dma1, .ld_cfg
  );

  assign gbyte = glob_cfg[int'(goff)*8 +: 8];

  always_comb begin
    host_rdata = 8'h00;
    if (idx_rd) host_rdata = index;
    else if (data_rd) begin
      if (index == IDX_LDN) host_rdata = 8'(ldn);
      else if (glob_hit)    host_rdata = gbyte;
      else if (dev_hit)     host_rdata = dev_byte;
    end
  end

  a_r2_ldn_reject: assert property (@(posedge clk) disable iff (rst)
    (data_wr && index == IDX_LDN && host_wdata > LDN_MAX) |=> $stable(ldn));
  a_r12_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !host_rd |-> host_rdata == 8'h00);
  a_r4_lock_bit7: assert property (@(posedge clk) disable iff (rst)
    lock |-> glob_cfg[15]);
endmodule

// File: tb/tb_sio_cfg_regfile.sv
module tb_sio_cfg_regfile;
  localparam int NL = 15;
  localparam int GN = 14;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, strap_hi, host_wr, host_rd;
  logic [15:0] host_addr;
  logic [7:0]  host_wdata, host_rdata;
  logic [NL-1:0]    ld_active;
  logic [NL*16-1:0] ld_base0, ld_base1;
  logic [NL*8-1:0]  ld_irq_sel, ld_irq_type, ld_dma0, ld_dma1;
  logic [NL*24-1:0] ld_cfg;
  logic [GN*8-1:0]  glob_cfg;

  sio_cfg_regfile dut (
    .clk, .rst, .strap_hi, .host_addr, .host_wr, .host_rd, .host_wdata,
    .host_rdata, .ld_active, .ld_base0, .ld_base1, .ld_irq_sel,
    .ld_irq_type, .ld_dma0, .ld_dma1, .ld_cfg, .glob_cfg
  );

  int n_chk = 0, n_bad = 0;
  logic [15:0] pb;
  bit [7:0] m_idx;
  int       m_ldn;
  bit [7:0] m_g [GN];
  bit       m_lock;
  bit [7:0] m_r [NL][11];
  bit       m_act [NL];
  bit [7:0] ilist [30] = '{8'h07, 8'h20, 8'h21, 8'h22, 8'h23, 8'h24, 8'h25,
    8'h26, 8'h27, 8'h28, 8'h29, 8'h2A, 8'h2B, 8'h2C, 8'h2D, 8'h30, 8'h60,
    8'h61, 8'h62, 8'h63, 8'h70, 8'h71, 8'h74, 8'h75, 8'hF0, 8'hF1, 8'hF2,
    8'h50, 8'h00, 8'hFF};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int b_slot(bit [7:0] i);
    case (i)
      8'h60: return 0;  8'h61: return 1;  8'h62: return 2;  8'h63: return 3;
      8'h70: return 4;  8'h71: return 5;  8'h74: return 6;  8'h75: return 7;
      8'hF0: return 8;  8'hF1: return 9;  8'hF2: return 10;
      default: return -1;
    endcase
  endfunction

  task automatic m_reset();
    m_idx = 0; m_ldn = 0; m_lock = 0;
    for (int k = 0; k < GN; k++) m_g[k] = 0;
    m_g[0] = 8'hE9; m_g[7] = 8'h01;
    for (int d = 0; d < NL; d++) begin
      m_act[d] = 0;
      for (int s = 0; s < 11; s++) m_r[d][s] = 0;
    end
    m_r[0][0] = 8'h03; m_r[0][1] = 8'hF2; m_r[0][4] = 8'h06; m_r[0][6] = 8'h02; m_r[0][8] = 8'h24;
    m_r[1][0] = 8'h02; m_r[1][1] = 8'h78; m_r[1][4] = 8'h07;
    m_r[2][0] = 8'h02; m_r[2][1] = 8'hF8; m_r[2][4] = 8'h03;
    m_r[3][0] = 8'h03; m_r[3][1] = 8'hF8; m_r[3][4] = 8'h04;
  endtask

  task automatic m_apply(bit [7:0] v);
    int s;
    s = b_slot(m_idx);
    if (m_idx == 8'h07) begin
      if (v <= 8'h0E) m_ldn = v;
    end else if (m_idx >= 8'h20 && m_idx <= 8'h2D) begin
      case (m_idx - 8'h20)
        1: if (!m_lock) begin m_g[1] = v; if (v[7]) m_lock = 1; end
        2, 4, 10: if (!m_lock) m_g[m_idx - 8'h20] = v;
        3:  if (!m_lock) m_g[3]  = v & 8'hF7;
        5:  if (!m_lock) m_g[5]  = v & 8'hF3;
        11: if (!m_lock) m_g[11] = v & 8'h4F;
        8, 12, 13: m_g[m_idx - 8'h20] = v & 8'hF3;
        default: ;
      endcase
    end else if (m_idx == 8'h30) m_act[m_ldn] = v[0] & m_g[0][0];
    else if (s >= 0) m_r[m_ldn][s] = (s == 4 || s == 6 || s == 7) ? (v & 8'h1F) : v;
  endtask

  function automatic bit [7:0] m_expect();
    int s;
    s = b_slot(m_idx);
    if (m_idx == 8'h07) return 8'(m_ldn);
    if (m_idx >= 8'h20 && m_idx <= 8'h2D) return m_g[m_idx - 8'h20];
    if (m_idx == 8'h30) return {7'b0, m_act[m_ldn]};
    if (s >= 0) return m_r[m_ldn][s];
    return 8'h00;
  endfunction

  task automatic do_reset(bit s);
    strap_hi = s; rst = 1; host_wr = 0; host_rd = 0; host_addr = 0; host_wdata = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    m_reset();
    pb = s ? 16'h004E : 16'h002E;
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] v);
    @(negedge clk);
    host_addr = a; host_wdata = v; host_wr = 1;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] v);
    @(negedge clk);
    host_addr = a; host_rd = 1;
    #1 v = host_rdata;
    #1 host_rd = 0;
  endtask

  task automatic set_reg(bit [7:0] i, bit [7:0] v);
    wr(pb, i); m_idx = i;
    wr(pb + 16'd1, v); m_apply(v);
  endtask

  task automatic chk_reg(string req, bit [7:0] i);
    logic [7:0] v;
    wr(pb, i); m_idx = i;
    rd(pb + 16'd1, v);
    chk(req, v, m_expect());
  endtask

  task automatic chk_ports(string req);
    for (int d = 0; d < NL; d++) begin
      chk(req, ld_active[d], m_act[d]);
      chk(req, ld_base0[d*16 +: 16], {m_r[d][0], m_r[d][1]});
      chk(req, ld_base1[d*16 +: 16], {m_r[d][2], m_r[d][3]});
      chk(req, ld_irq_sel[d*8 +: 8], m_r[d][4]);
      chk(req, ld_dma0[d*8 +: 8], m_r[d][6]);
      chk(req, ld_cfg[d*24 +: 24], {m_r[d][10], m_r[d][9], m_r[d][8]});
    end
    for (int k = 0; k < GN; k++) chk(req, glob_cfg[k*8 +: 8], m_g[k]);
  endtask

  task automatic rand_phase(int n, bit allow_lock);
    bit [7:0] i, v;
    for (int t = 0; t < n; t++) begin
      i = ilist[$urandom_range(0, 29)];
      v = 8'($urandom);
      if (i == 8'h07) v = 8'($urandom_range(0, 16));
      if (i == 8'h21 && !allow_lock) v[7] = 1'b0;
      set_reg(i, v);
      chk_reg("R9 random readback", i);
      if (t % 50 == 0) chk_ports("R9 random exports");
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h1D5E_2E4E));
    do_reset(1'b0);

    // R11 reset state
    rd(pb, v); chk("R11 index reset", v, 8'h00);
    chk_ports("R11 reset exports");
    chk_reg("R3 id byte", 8'h20);
    chk_reg("R3 reg27 default", 8'h27);
    chk_reg("R11 ldn0 base low", 8'h61);
    chk_reg("R11 ldn0 cfg F0", 8'hF0);
    // R12 idle read bus
    host_addr = pb + 16'd1; #1 chk("R12 idle rdata", host_rdata, 8'h00);

    // R2 LDN range
    set_reg(8'h07, 8'h0F); chk_reg("R2 reject 0x0F", 8'h07);
    set_reg(8'h07, 8'h0E); chk_reg("R2 accept 0x0E", 8'h07);
    set_reg(8'h07, 8'hFF); chk_reg("R2 reject 0xFF", 8'h07);

    // R3 read-only and holes
    set_reg(8'h20, 8'h00); chk_reg("R3 id ignores write", 8'h20);
    set_reg(8'h26, 8'hFF); chk_reg("R3 hole 26", 8'h26);
    set_reg(8'h27, 8'hAA); chk_reg("R3 reg27 write ignored", 8'h27);

    // R7 masks, R6 free registers
    set_reg(8'h23, 8'hFF); chk_reg("R7 mask 23", 8'h23);
    set_reg(8'h25, 8'hFF); chk_reg("R7 mask 25", 8'h25);
    set_reg(8'h2B, 8'hFF); chk_reg("R7 mask 2B", 8'h2B);
    set_reg(8'h22, 8'h5A); chk_reg("R7 unmasked 22", 8'h22);
    set_reg(8'h2C, 8'hFF); chk_reg("R6 mask 2C", 8'h2C);

    // R8 enable bit on LDN 5
    set_reg(8'h07, 8'h05);
    set_reg(8'h30, 8'hFF); chk_reg("R8 act read", 8'h30);
    #1 chk("R8 ld_active set", ld_active[5], 1'b1);
    set_reg(8'h30, 8'hFE); chk_reg("R8 act cleared", 8'h30);
    #1 chk("R8 ld_active clear", ld_active[5], 1'b0);

    // R9 masks of per-device selects
    set_reg(8'h70, 8'hFF); chk_reg("R9 mask 70", 8'h70);
    set_reg(8'h71, 8'hFF); chk_reg("R9 unmasked 71", 8'h71);
    set_reg(8'h75, 8'hE7); chk_reg("R9 mask 75", 8'h75);

    // R10 unmapped
    set_reg(8'h50, 8'h77); chk_reg("R10 unmapped 50", 8'h50);
    chk_reg("R10 unmapped 29", 8'h29);

    // R1 outside addresses
    wr(16'h004E, 8'h61);
    rd(pb, v); chk("R1 other base ignored", v, m_idx);
    rd(16'h002C, v); chk("R1 miss reads zero", v, 8'h00);

    rand_phase(400, 1'b0);

    // R4 / R5 lock
    set_reg(8'h21, 8'h83); chk_reg("R4 lock write", 8'h21);
    set_reg(8'h21, 8'h00); chk_reg("R4 lock bit7 stays", 8'h21);
    set_reg(8'h22, 8'h11); chk_reg("R5 locked 22", 8'h22);
    set_reg(8'h2B, 8'h00); chk_reg("R5 locked 2B", 8'h2B);
    set_reg(8'h2A, 8'h33); chk_reg("R5 locked 2A", 8'h2A);
    set_reg(8'h2D, 8'hFF); chk_reg("R6 free 2D while locked", 8'h2D);
    set_reg(8'h28, 8'h0C); chk_reg("R6 free 28 while locked", 8'h28);
    rand_phase(300, 1'b1);
    chk_ports("R5 exports after locked phase");

    // R1 strap high; R4 lock cleared by reset
    do_reset(1'b1);
    chk_reg("R1 strap base id", 8'h20);
    set_reg(8'h22, 8'h66); chk_reg("R4 lock cleared by reset", 8'h22);
    wr(16'h002E, 8'h07);
    rd(pb, v); chk("R1 low base ignored after strap", v, 8'h22);
    rd(16'h002F, v); chk("R1 low base read zero", v, 8'h00);
    rand_phase(200, 1'b1);
    chk_ports("R11 exports after strap run");

    summary();
    $finish;
  end
endmodule